// File: doc/BRIEF.md
# Stereo Interpolating Sigma-Delta DAC Front End

This block forms the digital part of a stereo oversampled DAC. Each channel takes one signed 16-bit sample per sample period. A linear interpolator raises the rate by 8. Each interpolated level is then held for 16 ticks of a single-bit, second-order noise-shaping modulator. The modulator therefore runs at 128 times the sample rate, and its one-bit stream per channel feeds an external analog low-pass filter. A density of ones near one half means zero, near one means positive full scale, and near zero means negative full scale.

The block runs from any clock at least as fast as 128 fs. The `mod_en` strobe marks each modulator tick, so any sample rate from 5 kHz to 48 kHz uses the same 128:1 ratio. The block derives the 8 fs step events and the fs capture events from `mod_en` with a small sequencer. The sequencer has four named states:
- IDLE: the state after reset; its first tick is a capture.
- HOLD: the level is held while ticks are counted.
- STEP: the next tick advances the interpolated level.
- LOAD: the next tick captures new samples.

The transitions are:
- IDLE goes to HOLD on its first tick.
- LOAD goes to HOLD on a tick.
- STEP goes to HOLD on a tick.
- HOLD goes to STEP after 15 hold ticks, or to LOAD instead when the seventh step of the period has been taken.

Without a tick, every state holds. `sample_take` is high during the tick in which the inputs are captured, which lets upstream logic pace its samples.

Top module: `dac_ovs_chain`

## Requirements
- R1: `sample_take` is high on the first tick (cycle with `mod_en` high) after reset, and after that on exactly every 128th tick. Both `left_in` and `right_in` are captured in that tick.
- R2: After a capture, each channel's internal level starts at the previously captured sample and rises in 8 equal increments toward the new one. Each level is held for 16 ticks. Counted over the 128 ticks after the capture tick, the number of ones is 64 + (p + 7(n-p)/16)/512 within ±3, where p is the previous sample and n is the new one.
- R3: For a constant input x with |x| ≤ 16384, the number of ones over a 128-tick period after capture is 64 + x/512 within ±3. So zero input gives density one half.
- R4: Both modulator integrators saturate instead of wrapping. A sustained input of +32767 gives at least 116 ones in a 128-tick period by the third period. A sustained input of -32768 gives at most 12 ones.
- R5: In a cycle with `mod_en` low, `bit_l`, `bit_r` and all internal state keep their values, and `sample_take` is low.
- R6: Reset clears the interpolator and integrator state and sets both output bits to 1. With zero input, the bits after ticks 1, 2, 3, 4, … follow the repeating pattern 0, 0, 1, 1.
- R7: The two channels are identical and independent. Each stream depends only on its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at least 128 times the sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_en | input | 1 | Modulator tick strobe at 128 fs |
| left_in | input | 16 | Left sample, signed two's complement |
| right_in | input | 16 | Right sample, signed two's complement |
| sample_take | output | 1 | High in the tick that captures both inputs |
| bit_l | output | 1 | Left one-bit stream |
| bit_r | output | 1 | Right one-bit stream |

## Verification
The bench counts ones over whole capture periods. It targets the first period after an input step, where the ramp must start at the old sample. A design that captured one period late, or jumped straight to the new value, would be off by several ones in that period.

Full-scale inputs in opposite directions on the two channels expose integrators that wrap. A wrapping integrator would flip the density toward the wrong rail. Stalled ticks reveal state that advances without `mod_en`. A reset in the middle of a run must bring back the exact 0, 0, 1, 1 start pattern, which fails if any integrator or interpolator register keeps its old value.

// File: rtl/dac_ovs_pkg.sv
package dac_ovs_pkg;

    // Sequencer state: names what the next tick will do
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_STEP = 2'd2,
        SEQ_LOAD = 2'd3
    } seq_state_e;

    // Clamp a signed value to the range of a w-bit two's complement word
    function automatic int sat_to(input int v, input int w);
        int hi;
        int lo;
        hi = (1 <<< (w - 1)) - 1;
        lo = -(1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/dac_rate_seq.sv
module dac_rate_seq
    import dac_ovs_pkg::*;
#(
    parameter int HOLD   = 16,  // ticks per interpolated level (>= 2)
    parameter int INTERP = 8    // levels per sample period
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic load_stb,
    output logic step_stb
);

    localparam int HC_W = (HOLD > 2) ? $clog2(HOLD) : 1;
    localparam int PH_W = (INTERP > 1) ? $clog2(INTERP) : 1;
    localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD - 2);
    localparam logic [PH_W-1:0] PH_LAST   = PH_W'(INTERP - 1);

    seq_state_e      state_q, state_d;
    logic [HC_W-1:0] hold_q, hold_d;
    logic [PH_W-1:0] phase_q, phase_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            hold_q  <= '0;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            phase_q <= phase_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        phase_d = phase_q;
        if (tick_en) begin
            unique case (state_q)
                SEQ_IDLE, SEQ_LOAD: begin
                    state_d = SEQ_HOLD;
                    hold_d  = '0;
                    phase_d = '0;
                end
                SEQ_STEP: begin
                    state_d = SEQ_HOLD;
                    hold_d  = '0;
                    phase_d = phase_q + PH_W'(1);
                end
                SEQ_HOLD: begin
                    if (hold_q == HOLD_LAST) begin
                        state_d = (phase_q == PH_LAST) ? SEQ_LOAD : SEQ_STEP;
                    end else begin
                        hold_d = hold_q + HC_W'(1);
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        load_stb = 1'b0;
        step_stb = 1'b0;
        unique case (state_q)
            SEQ_IDLE, SEQ_LOAD: load_stb = tick_en;
            SEQ_STEP:           step_stb = tick_en;
            SEQ_HOLD:           ;
            default:            ;
        endcase
    end

endmodule

// File: rtl/dac_lin_interp.sv
module dac_lin_interp #(
    parameter int DATA_W = 16,
    parameter int INTERP = 8    // power of two
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_stb,
    input  logic                     step_stb,
    input  logic signed [DATA_W-1:0] sample_in,
    output logic signed [DATA_W-1:0] level
);

    localparam int SH    = $clog2(INTERP);
    localparam int DLT_W = DATA_W + 1;
    localparam int ACC_W = DLT_W + SH;

    logic signed [DATA_W-1:0] cur_q;
    logic signed [DLT_W-1:0]  dlt_q;
    logic signed [ACC_W-1:0]  acc_q;

    logic signed [DLT_W-1:0]  new_x, cur_x;
    logic signed [ACC_W-1:0]  base_w, inc_w;

    always_comb begin
        new_x  = {sample_in[DATA_W-1], sample_in};
        cur_x  = {cur_q[DATA_W-1], cur_q};
        base_w = {{(ACC_W-DATA_W){cur_q[DATA_W-1]}}, cur_q} <<< SH;
        inc_w  = {{(ACC_W-DLT_W){dlt_q[DLT_W-1]}}, dlt_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            dlt_q <= '0;
            acc_q <= '0;
        end else if (load_stb) begin
            cur_q <= sample_in;
            dlt_q <= new_x - cur_x;
            acc_q <= base_w;
        end else if (step_stb) begin
            acc_q <= acc_q + inc_w;
        end
    end

    // Level lies between two in-range samples, so the slice cannot overflow
    assign level = acc_q[SH +: DATA_W];

endmodule

// File: rtl/dac_sd2_mod.sv
module dac_sd2_mod
    import dac_ovs_pkg::*;
#(
    parameter int DATA_W = 16   // at most 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic signed [DATA_W-1:0] x_in,
    output logic                     bit_out
);

    localparam int FS   = 1 <<< (DATA_W - 1);
    localparam int I1_W = DATA_W + 3;
    localparam int I2_W = DATA_W + 5;

    logic signed [I1_W-1:0] i1_q, i1_d;
    logic signed [I2_W-1:0] i2_q, i2_d;
    logic                   bit_q;

    int fb, s1, s2;

    always_comb begin
        fb   = bit_q ? FS : -FS;
        s1   = int'(i1_q) + int'(x_in) - fb;
        i1_d = I1_W'(sat_to(s1, I1_W));
        s2   = int'(i2_q) + int'(i1_d) - fb;
        i2_d = I2_W'(sat_to(s2, I2_W));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i1_q  <= '0;
            i2_q  <= '0;
            bit_q <= 1'b1;
        end else if (tick_en) begin
            i1_q  <= i1_d;
            i2_q  <= i2_d;
            bit_q <= ~i2_d[I2_W-1];
        end
    end

    assign bit_out = bit_q;

endmodule

// File: rtl/dac_ovs_chain.sv
module dac_ovs_chain #(
    parameter int DATA_W = 16,
    parameter int INTERP = 8,
    parameter int HOLD   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic [DATA_W-1:0] left_in,
    input  logic [DATA_W-1:0] right_in,
    output logic              sample_take,
    output logic              bit_l,
    output logic              bit_r
);

    localparam int NCH = 2;

    logic                     load_stb;
    logic                     step_stb;
    logic signed [DATA_W-1:0] smp    [NCH];
    logic signed [DATA_W-1:0] ip_val [NCH];
    logic                     bits   [NCH];

    assign smp[0] = $signed(left_in);
    assign smp[1] = $signed(right_in);

    dac_rate_seq #(.HOLD(HOLD), .INTERP(INTERP)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (mod_en),
        .load_stb (load_stb),
        .step_stb (step_stb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dac_lin_interp #(.DATA_W(DATA_W), .INTERP(INTERP)) ip_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_stb  (load_stb),
            .step_stb  (step_stb),
            .sample_in (smp[c]),
            .level     (ip_val[c])
        );
        dac_sd2_mod #(.DATA_W(DATA_W)) mod_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (mod_en),
            .x_in    (ip_val[c]),
            .bit_out (bits[c])
        );
    end

    assign sample_take = load_stb;
    assign bit_l       = bits[0];
    assign bit_r       = bits[1];

endmodule

// File: rtl/dac_ovs_chain_chk.sv
module dac_ovs_chain_chk #(
    parameter int DATA_W = 16,
    parameter int INTERP = 8,
    parameter int HOLD   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mod_en,
    input logic                     sample_take,
    input logic                     step_stb,
    input logic                     bit_l,
    input logic                     bit_r,
    input logic signed [DATA_W-1:0] ip_l,
    input logic signed [DATA_W-1:0] ip_r
);

    localparam int TICKS = INTERP * HOLD;

    int   take_gap;
    logic take_seen;
    int   evt_gap;
    logic evt_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_gap  <= 0;
            take_seen <= 1'b0;
            evt_gap   <= 0;
            evt_seen  <= 1'b0;
        end else if (mod_en) begin
            if (sample_take) begin
                take_gap  <= 0;
                take_seen <= 1'b1;
            end else begin
                take_gap <= take_gap + 1;
            end
            if (sample_take || step_stb) begin
                evt_gap  <= 0;
                evt_seen <= 1'b1;
            end else begin
                evt_gap <= evt_gap + 1;
            end
        end
    end

    // R1: captures are a fixed number of ticks apart
    a_r1_take_period: assert property (@(posedge clk) disable iff (!rst_n)
        (take_seen && sample_take) |-> (take_gap == TICKS - 1));

    // R2: each interpolated level lasts HOLD ticks
    a_r2_hold_span: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_seen && (sample_take || step_stb)) |-> (evt_gap == HOLD - 1));

    // R2: levels change only on a capture or step
    a_r2_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_take && !step_stb) |=> ($stable(ip_l) && $stable(ip_r)));

    // R5: no tick, no change at the outputs
    a_r5_bits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> ($stable(bit_l) && $stable(bit_r)));

    // R6: both bits start at one when reset is released
    a_r6_reset_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bit_l && bit_r));

endmodule

bind dac_ovs_chain dac_ovs_chain_chk #(
    .DATA_W (DATA_W),
    .INTERP (INTERP),
    .HOLD   (HOLD)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_en      (mod_en),
    .sample_take (sample_take),
    .step_stb    (step_stb),
    .bit_l       (bit_l),
    .bit_r       (bit_r),
    .ip_l        (ip_val[0]),
    .ip_r        (ip_val[1])
);

// File: tb/dac_ovs_chain_tb_top.sv
module dac_ovs_chain_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mod_en;
    logic [15:0] left_in;
    logic [15:0] right_in;
    logic        sample_take;
    logic        bit_l;
    logic        bit_r;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   frz_bad = 0;
    logic stall_mode = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    dac_ovs_chain dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mod_en      (mod_en),
        .left_in     (left_in),
        .right_in    (right_in),
        .sample_take (sample_take),
        .bit_l       (bit_l),
        .bit_r       (bit_r)
    );

    localparam int NV = 8;
    localparam logic signed [15:0] VL [NV] = '{
        16'sd0, 16'sd8192, 16'sd16384, -16'sd16384,
        16'sd4096, -16'sd8192, 16'sd0, 16'sd12288 };
    localparam logic signed [15:0] VR [NV] = '{
        16'sd0, -16'sd8192, 16'sd0, 16'sd12288,
        -16'sd4096, 16'sd16384, -16'sd16384, 16'sd0 };

    task automatic chk(input string tag, input int act, input int exp, input int tol);
        int d;
        n_tests++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (tol %0d)", tag, act, exp, tol);
        end
    endtask

    // Called at a falling edge; performs one modulator tick
    task automatic tick(output logic took, output logic bl, output logic br);
        mod_en = 1'b1;
        #1;
        took = sample_take;
        @(negedge clk);
        bl = bit_l;
        br = bit_r;
        if (stall_mode) begin
            mod_en = 1'b0;
            #1;
            if (sample_take !== 1'b0) frz_bad++;
            @(negedge clk);
            if (bit_l !== bl || bit_r !== br) frz_bad++;
        end
    endtask

    task automatic wait_take();
        logic t, bl, br;
        for (int i = 0; i < 300; i++) begin
            tick(t, bl, br);
            if (t) break;
        end
    endtask

    // Count ones over the 128 ticks after a capture
    task automatic window(output int ol, output int orr);
        logic t, bl, br;
        int   bad;
        ol = 0; orr = 0; bad = 0;
        for (int i = 1; i <= 128; i++) begin
            tick(t, bl, br);
            ol  += int'(bl);
            orr += int'(br);
            if ((i != 128) && t) bad++;
            if ((i == 128) && !t) bad++;
        end
        chk("R1 capture period", bad, 0, 0);
    endtask

    task automatic reset_pattern();
        logic t, bl, br;
        left_in  = '0;
        right_in = '0;
        stall_mode = 1'b0;
        mod_en = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R6 left bit after reset", int'(bit_l), 1, 0);
        chk("R6 right bit after reset", int'(bit_r), 1, 0);
        for (int k = 1; k <= 8; k++) begin
            tick(t, bl, br);
            if (k == 1) chk("R1 first tick captures", int'(t), 1, 0);
            chk("R6 left start pattern", int'(bl), (((k - 1) % 4) >= 2) ? 1 : 0, 0);
            chk("R6 R7 right start pattern", int'(br), (((k - 1) % 4) >= 2) ? 1 : 0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int pl, pr, c1l, c1r, c2l, c2r, e, m;
        rst_n    = 1'b0;
        mod_en   = 1'b0;
        left_in  = '0;
        right_in = '0;
        @(negedge clk);

        reset_pattern();

        // Table walk: ramp period then steady period per vector
        pl = 0; pr = 0;
        for (int v = 0; v < NV; v++) begin
            left_in    = VL[v];
            right_in   = VR[v];
            stall_mode = (v >= 5);
            wait_take();
            window(c1l, c1r);
            window(c2l, c2r);
            m = pl + (7 * (int'(VL[v]) - pl)) / 16;
            chk("R2 left ramp period", c1l, 64 + m / 512, 3);
            m = pr + (7 * (int'(VR[v]) - pr)) / 16;
            chk("R2 R7 right ramp period", c1r, 64 + m / 512, 3);
            e = 64 + int'(VL[v]) / 512;
            chk("R3 left steady density", c2l, e, 3);
            e = 64 + int'(VR[v]) / 512;
            chk("R3 R7 right steady density", c2r, e, 3);
            pl = int'(VL[v]);
            pr = int'(VR[v]);
        end
        stall_mode = 1'b0;
        chk("R5 stalled ticks hold state", frz_bad, 0, 0);

        // Full scale in opposite directions
        left_in  = 16'sh7FFF;
        right_in = 16'sh8000;
        wait_take();
        window(c1l, c1r);
        window(c1l, c1r);
        window(c2l, c2r);
        chk("R4 positive full scale", c2l, 128, 12);
        chk("R4 R7 negative full scale", c2r, 0, 12);

        // Reset in the middle of a run
        reset_pattern();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule